// File: doc/BRIEF.md
# Text-Mode Video Address Generator

This block produces the screen memory address and the character-cell row index for a 40-column text display. It runs on the character clock. A display-enable input from the horizontal timing marks the active part of each raster line, and a frame-start strobe from the vertical timing returns everything to the top of the screen. The 10-bit address drives the screen memory. The 3-bit row index goes with the fetched character code to a character generator.

The address is built from two counters. A 2-bit low counter is cleared at every line start. An 8-bit upper counter is reloaded at every line start from an 8-bit line-start register, and it steps each time the low counter wraps. The counter runs freely during blanking. At the end of the eighth raster line of a character line, the line-start register captures the upper bits of the address that follows the last character. The next character line then begins 40 addresses further on.

Because the line-start register holds only the upper bits, an extra line-start event has a known effect. If display enable drops for one cycle just after a line starts, the counters reload and the first character repeats. The next character line then begins only 36 addresses on. The block reproduces this on purpose.

Top module: `vid_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o and row_o are zero.
- R2: On a rising edge of disp_en_i, the internal address loads the line-start value with its two low bits zero. addr_o shows that value one clock later.
- R3: After each load, the address increments by one per clock. addr_o follows it with one clock of latency.
- R4: The address keeps incrementing after disp_en_i falls, through the whole blanking interval.
- R5: row_o advances by one at the end of each active span and wraps from 7 to 0.
- R6: The line-start value changes only at the end of an active span in row 7. It becomes the upper 8 bits of (last displayed address + 1), so a full 40-character line moves the next character line 40 addresses on. Rows 0 to 6 restart at the same address.
- R7: An active span that lasts exactly one clock is treated as a glitch. It does not advance row_o and does not update the line-start value.
- R8: Suppose a line start is followed by one low cycle and then a second start. The address reloads, so the start address repeats. If that line then shows 39 more characters in row 7, the next character line starts 36 addresses after the current one.
- R9: A frame_start_i pulse clears the address, addr_o, the row index and the line-start value, so the next line starts at address 0 in row 0.
- R10: Address arithmetic is modulo 1024, and the line-start value is modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Synchronous frame restart strobe |
| disp_en_i | input | 1 | Horizontal display enable, high for the active characters |
| addr_o | output | 10 | Registered screen memory address |
| row_o | output | 3 | Raster row within the character cell |

## Verification
The bench sweeps whole frames of 40-character lines and computes each expected address from the line start and the cycle offset. It checks the active part and the blanking part of every line separately, which tells a free-running counter apart from a frozen one. A run of more than 26 character lines crosses the 1024 wrap. Glitched lines are placed in a non-final row and in row 7. This separates the row and line-start bookkeeping from the counter reload, and it confirms the 36-address step. Frame-start pulses in the middle of a frame show that every piece of state clears.

// File: rtl/vag_pkg.sv
`timescale 1ns/1ps
package vag_pkg;
  localparam int LOW_W = 2;
  localparam int UP_W  = 8;
  localparam int ROW_W = 3;
endpackage

// File: rtl/vag_low_ctr.sv
`timescale 1ns/1ps
module vag_low_ctr #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= q_o + W'(1);
  end

  assign wrap_o = &q_o;

  p_low_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/vag_up_ctr.sv
`timescale 1ns/1ps
module vag_up_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + W'(1);
  end

  p_up_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !inc_i) |=> $stable(q_o));
endmodule

// File: rtl/vag_line_latch.sv
`timescale 1ns/1ps
module vag_line_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cap_i) |=> $stable(q_o));
endmodule

// File: rtl/vag_row_ctr.sv
`timescale 1ns/1ps
module vag_row_ctr #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (adv_i) q_o <= q_o + W'(1);
  end

  p_row_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && (q_o == '1)) |=> (q_o == '0));
endmodule

// File: rtl/vid_addr_gen.sv
`timescale 1ns/1ps
module vid_addr_gen #(
  parameter int LOW_W = vag_pkg::LOW_W,
  parameter int UP_W  = vag_pkg::UP_W,
  parameter int ROW_W = vag_pkg::ROW_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_start_i,
  input  logic                   disp_en_i,
  output logic [LOW_W+UP_W-1:0]  addr_o,
  output logic [ROW_W-1:0]       row_o
);
  localparam int ADDR_W = LOW_W + UP_W;

  logic              de_q, de_q2;
  logic              line_start, line_end, cap;
  logic              low_wrap;
  logic [LOW_W-1:0]  low_q;
  logic [UP_W-1:0]   up_q, latch_q, up_next;
  logic [ADDR_W-1:0] cnt_q;
  logic [ROW_W-1:0]  row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q  <= 1'b0;
      de_q2 <= 1'b0;
    end else begin
      de_q  <= disp_en_i;
      de_q2 <= de_q;
    end
  end

  assign line_start = disp_en_i & ~de_q;
  // a one-cycle active span is a glitch, not a line end
  assign line_end   = ~disp_en_i & de_q & de_q2;
  assign cap        = line_end & (row_q == '1);
  assign up_next    = up_q + UP_W'(low_wrap);

  vag_low_ctr #(.W(LOW_W)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i | line_start),
    .q_o    (low_q),
    .wrap_o (low_wrap)
  );

  vag_up_ctr #(.W(UP_W)) u_up (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (frame_start_i),
    .load_i     (line_start),
    .load_val_i (latch_q),
    .inc_i      (low_wrap),
    .q_o        (up_q)
  );

  vag_line_latch #(.W(UP_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .cap_i  (cap),
    .d_i    (up_next),
    .q_o    (latch_q)
  );

  vag_row_ctr #(.W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .adv_i  (line_end),
    .q_o    (row_q)
  );

  assign cnt_q = {up_q, low_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            addr_o <= '0;
    else if (frame_start_i) addr_o <= '0;
    else                    addr_o <= cnt_q;
  end

  assign row_o = row_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start && !frame_start_i) |=> (cnt_q == {$past(latch_q), {LOW_W{1'b0}}}));

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start && !frame_start_i) |=> (cnt_q == ($past(cnt_q) + ADDR_W'(1))));

  p_glitch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disp_en_i && de_q && !de_q2 && !frame_start_i) |=> $stable(row_o));

  p_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cnt_q == '0 && row_o == '0 && latch_q == '0 && addr_o == '0));
endmodule

// File: tb/sim_vid_addr_gen.sv
`timescale 1ns/1ps
module sim_vid_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic       de = 1'b0;
  logic [9:0] addr;
  logic [2:0] row;

  int n_chk = 0;
  int n_fail = 0;
  int exp_start = 0;
  int exp_row = 0;

  always #2.5 clk = ~clk;

  vid_addr_gen u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_start_i (fs),
    .disp_en_i     (de),
    .addr_o        (addr),
    .row_o         (row)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one raster line of 48 slots; glitch: high, low, then 39 high
  task automatic run_line(input bit glitch);
    int s = exp_start;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (!glitch) begin
        if (i >= 2) begin
          int e = (s + i - 2) % 1024;
          string tag = (i == 2) ? "R2 R6" : ((s + i - 2) >= 1024) ? "R10" : (i - 2 < 40) ? "R3" : "R4";
          chk(int'(addr) == e, tag, int'(addr), e);
        end
        de = (i < 40);
      end else begin
        if (i >= 2) begin
          int e = (i == 2) ? s : (i == 3) ? (s + 1) % 1024 : (s + i - 4) % 1024;
          chk(int'(addr) == e, "R8", int'(addr), e);
        end
        de = (i == 0) || (i >= 2 && i <= 40);
      end
    end
    chk(int'(row) == (exp_row + 1) % 8, glitch ? "R7" : "R5", int'(row), (exp_row + 1) % 8);
    if (exp_row == 7)
      exp_start = glitch ? (((s + 39) / 4) * 4) % 1024 : (s + 40) % 1024;
    exp_row = (exp_row + 1) % 8;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    fs = 1'b1;
    de = 1'b0;
    @(negedge clk);
    fs = 1'b0;
    chk(addr == 10'd0, "R9", int'(addr), 0);
    chk(row == 3'd0, "R9", int'(row), 0);
    exp_start = 0;
    exp_row = 0;
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(addr == 10'd0, "R1", int'(addr), 0);
    chk(row == 3'd0, "R1", int'(row), 0);
    rst_n = 1'b1;
    frame_pulse();
    for (int l = 0; l < 40; l++) run_line(1'b0);
    for (int l = 0; l < 3; l++) run_line(1'b0);
    run_line(1'b1);               // glitch in row 3: start must stay
    for (int l = 0; l < 3; l++) run_line(1'b0);
    run_line(1'b1);               // glitch in row 7: next start +36
    for (int l = 0; l < 8; l++) run_line(1'b0);
    // partial frame, then restart mid-frame
    for (int l = 0; l < 13; l++) run_line(1'b0);
    frame_pulse();
    for (int l = 0; l < 224; l++) run_line(1'b0);
    frame_pulse();
    run_line(1'b0);
    summary();
  end
endmodule